// File: doc/BRIEF.md
# Asynchronous Bus Cycle Master Sequencer

This block is the bus-master side of a parallel bus with a handshake acknowledge. A local client asks for one read or one write by pulsing a start request together with direction, address, function code, two byte selects and write data. The block then drives one bus cycle: function code, address, address strobe, upper and lower data strobes, the read/write line and a write-data drive enable. It waits for the slave's active-low acknowledge and, when the cycle ends, returns read data and a one-clock done pulse.

The block runs on a clock at twice the bus clock rate. One register step is therefore one half-state of the bus cycle, and the bus clock is a divided output of the block. A cycle without waits covers eight half-states, S0 to S7, and then one half-state of write-data hold. The time at which each bus signal changes depends on the cycle direction. On a read, the data strobes go active together with the address strobe. On a write, the data strobes follow one half-state after the write data is driven. Whole bus-clock wait states are added between S4 and S5 until the synchronized acknowledge arrives.

Top module: `bus_cycle_master`

## Requirements
- R1: `bclk_o` toggles on every `clk_i` edge after reset, and it is high in S0, S2, S4 and S6. S0 always starts with `bclk_o` high: a request accepted while `bclk_o` is high waits one clock before S0.
- R2: `fc_o` carries the latched function code from S0 to S7. `addr_o` carries the latched address from S1 to S7. Both outputs are zero at all other times.
- R3: `as_n_o` is low from S2 to S6, including any wait states. On a read (`rw_i`=1), each strobe whose byte select is set goes low during the same window (`be_i[1]` drives `uds_n_o`, `be_i[0]` drives `lds_n_o`).
- R4: On a write (`rw_i`=0), `rw_o` is low from S2 to S6, `data_oe_o` rises in S3, and the selected strobes are low from S4 to S6. On a read, `rw_o` stays high for the whole cycle.
- R5: `dtack_n_i` passes through a two-flop synchronizer. The synchronized acknowledge is examined first at the end of S4, and then once per bus clock at the end of each wait high half. Each missing acknowledge adds exactly two half-states.
- R6: In S7 the address strobe and the data strobes are high, `rw_o` is high, and `done_o` is high for exactly one clock.
- R7: On a write, `data_oe_o` stays high through S7 and one further half-state, then falls. `data_o` holds the latched write data.
- R8: On a read, `rdata_o` captures `data_i` at the edge that enters S7 and holds it afterwards.
- R9: A start is accepted only while the block is idle and at least one byte select is set. Any other start has no effect on the bus.
- R10: While `rst_ni` is low, the strobes and `rw_o` are high, and `data_oe_o`, `done_o`, `bclk_o`, `addr_o` and `fc_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the bus clock rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Cycle request |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | AW | Request address |
| fc_i | input | FW | Request function code |
| be_i | input | 2 | Byte selects, [1] upper, [0] lower |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data |
| done_o | output | 1 | One-clock end-of-cycle pulse |
| bclk_o | output | 1 | Divided bus clock |
| fc_o | output | FW | Bus function code |
| addr_o | output | AW | Bus address |
| as_n_o | output | 1 | Address strobe, active low |
| uds_n_o | output | 1 | Upper data strobe, active low |
| lds_n_o | output | 1 | Lower data strobe, active low |
| rw_o | output | 1 | Bus read/write line |
| data_o | output | DW | Bus write data |
| data_oe_o | output | 1 | Write data drive enable |
| data_i | input | DW | Bus read data |
| dtack_n_i | input | 1 | Slave acknowledge, active low, asynchronous |

## Verification
Clock k counts from the edge that enters S0. With L = 2n for n wait states, the address strobe is due low in clocks 2 to 6+L. Write strobes are due in clocks 4 to 6+L, `done_o` in clock 7+L, and the write drive ends after clock 8+L. An acknowledge driven low before edge j yields n = 0 for j up to 3 and n = ceil((j-3)/2) above that. The bench computes L from j, starts every request in a low bus-clock half so that clock 0 is fixed, and compares every output in every clock on the falling clock edge. Each idle-state test keeps observing the strobes for several clocks after its stimulus.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ALIGN, ST_S0, ST_S1, ST_S2, ST_S3, ST_S4,
    ST_W0, ST_W1, ST_S5, ST_S6, ST_S7, ST_TAIL
  } bcm_state_e;
endpackage

// File: rtl/bcm_sync.sv
module bcm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_n_i,
  output logic ack_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '1;
    else         q <= {q[STAGES-2:0], ack_n_i};
  end

  assign ack_o = ~q[STAGES-1];
endmodule

// File: rtl/bcm_seq.sv
module bcm_seq
  import bcm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       be_any_i,
  input  logic       ack_i,
  output bcm_state_e state_o,
  output logic       ph_o,
  output logic       accept_o
);
  bcm_state_e state_q, state_d;
  logic ph_q;

  assign accept_o = (state_q == ST_IDLE) && start_i && be_any_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_o) state_d = ph_q ? ST_ALIGN : ST_S0;
      ST_ALIGN: state_d = ST_S0;
      ST_S0:    state_d = ST_S1;
      ST_S1:    state_d = ST_S2;
      ST_S2:    state_d = ST_S3;
      ST_S3:    state_d = ST_S4;
      ST_S4:    state_d = ack_i ? ST_S5 : ST_W0;
      ST_W0:    state_d = ST_W1;
      ST_W1:    state_d = ack_i ? ST_S5 : ST_W0;
      ST_S5:    state_d = ST_S6;
      ST_S6:    state_d = ST_S7;
      ST_S7:    state_d = ST_TAIL;
      ST_TAIL:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ~ph_q;
    end
  end

  assign state_o = state_q;
  assign ph_o    = ph_q;
endmodule

// File: rtl/bcm_pins.sv
module bcm_pins
  import bcm_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int FW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bcm_state_e    state_i,
  input  logic          accept_i,
  input  logic          rw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [FW-1:0] fc_i,
  input  logic [1:0]    be_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic [FW-1:0] fc_o,
  output logic [AW-1:0] addr_o,
  output logic          as_n_o,
  output logic          uds_n_o,
  output logic          lds_n_o,
  output logic          rw_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o
);
  logic          rd_q;
  logic [AW-1:0] addr_q;
  logic [FW-1:0] fc_q;
  logic [1:0]    be_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic in_s0_s7, in_s1_s7, in_s2_s6, in_s3_s6, in_s4_s6, ds_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= 1'b1;
      addr_q  <= '0;
      fc_q    <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept_i) begin
        rd_q    <= rw_i;
        addr_q  <= addr_i;
        fc_q    <= fc_i;
        be_q    <= be_i;
        wdata_q <= wdata_i;
      end
      if (state_i == ST_S6 && rd_q) rdata_q <= data_i;
    end
  end

  // wait states sit between S4 and S5
  assign in_s4_s6 = state_i inside {ST_S4, ST_W0, ST_W1, ST_S5, ST_S6};
  assign in_s3_s6 = in_s4_s6 || state_i == ST_S3;
  assign in_s2_s6 = in_s3_s6 || state_i == ST_S2;
  assign in_s1_s7 = in_s2_s6 || state_i inside {ST_S1, ST_S7};
  assign in_s0_s7 = in_s1_s7 || state_i == ST_S0;
  assign ds_win   = rd_q ? in_s2_s6 : in_s4_s6;

  assign fc_o      = in_s0_s7 ? fc_q : '0;
  assign addr_o    = in_s1_s7 ? addr_q : '0;
  assign as_n_o    = ~in_s2_s6;
  assign uds_n_o   = ~(ds_win && be_q[1]);
  assign lds_n_o   = ~(ds_win && be_q[0]);
  assign rw_o      = rd_q || !in_s2_s6;
  assign data_oe_o = !rd_q && (in_s3_s6 || state_i inside {ST_S7, ST_TAIL});
  assign data_o    = wdata_q;
  assign done_o    = state_i == ST_S7;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/bus_cycle_master.sv
module bus_cycle_master
  import bcm_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int FW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [FW-1:0] fc_i,
  input  logic [1:0]    be_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic          bclk_o,
  output logic [FW-1:0] fc_o,
  output logic [AW-1:0] addr_o,
  output logic          as_n_o,
  output logic          uds_n_o,
  output logic          lds_n_o,
  output logic          rw_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  input  logic [DW-1:0] data_i,
  input  logic          dtack_n_i
);
  bcm_state_e state;
  logic ack_s, accept;

  bcm_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .ack_n_i(dtack_n_i), .ack_o(ack_s)
  );

  bcm_seq u_seq (
    .clk_i, .rst_ni, .start_i, .be_any_i(|be_i), .ack_i(ack_s),
    .state_o(state), .ph_o(bclk_o), .accept_o(accept)
  );

  bcm_pins #(.AW(AW), .DW(DW), .FW(FW)) u_pins (
    .clk_i, .rst_ni, .state_i(state), .accept_i(accept),
    .rw_i, .addr_i, .fc_i, .be_i, .wdata_i, .data_i,
    .rdata_o, .done_o, .fc_o, .addr_o, .as_n_o, .uds_n_o, .lds_n_o,
    .rw_o, .data_o, .data_oe_o
  );
endmodule

// File: rtl/bcm_chk.sv
module bcm_chk #(
  parameter int AW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bclk_o,
  input logic          as_n_o,
  input logic          uds_n_o,
  input logic          lds_n_o,
  input logic          rw_o,
  input logic          data_oe_o,
  input logic          done_o,
  input logic [AW-1:0] addr_o
);
  // R1
  bclk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> bclk_o != $past(bclk_o));

  // R3
  as_high_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(as_n_o) |-> bclk_o);

  // R2
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_n_o && $past(!as_n_o)) |-> $stable(addr_o));

  // R4
  write_ds_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rw_o && !(uds_n_o && lds_n_o)) |-> data_oe_o);

  // R6
  done_negated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (as_n_o && uds_n_o && lds_n_o && rw_o));

  // R7
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(data_oe_o) |-> $past(as_n_o));
endmodule

bind bus_cycle_master bcm_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bclk_o(bclk_o), .as_n_o(as_n_o),
  .uds_n_o(uds_n_o), .lds_n_o(lds_n_o), .rw_o(rw_o),
  .data_oe_o(data_oe_o), .done_o(done_o), .addr_o(addr_o)
);

// File: tb/tb_bus_cycle_master.sv
`timescale 1ns/1ps
module tb_bus_cycle_master;
  localparam int AW = 24, DW = 16, FW = 3;

  typedef struct packed {
    logic          rd;
    logic [1:0]    be;
    logic [FW-1:0] fc;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic [3:0]    j;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'b11, 3'd5, 24'h00_1234, 16'h0000, 16'hbeef, 4'd1},
    '{1'b0, 2'b11, 3'd1, 24'h0a_0002, 16'h5a5a, 16'h0000, 4'd2},
    '{1'b1, 2'b10, 3'd6, 24'h7f_fff0, 16'h0000, 16'hc3a5, 4'd4},
    '{1'b0, 2'b01, 3'd2, 24'h12_3457, 16'h00ff, 16'h0000, 4'd5},
    '{1'b1, 2'b01, 3'd3, 24'hff_ffff, 16'h0000, 16'h0f0f, 4'd6},
    '{1'b0, 2'b10, 3'd7, 24'h00_0100, 16'habcd, 16'h0000, 4'd9},
    '{1'b1, 2'b11, 3'd0, 24'h80_0000, 16'h0000, 16'h1357, 4'd3}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start = 1'b0, rw = 1'b1, dtack_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [FW-1:0] fc = '0;
  logic [1:0] be = '0;
  logic [DW-1:0] wdata = '0, din = '0;
  logic [DW-1:0] rdata_o, data_o;
  logic done_o, bclk_o, as_n_o, uds_n_o, lds_n_o, rw_o, data_oe_o;
  logic [FW-1:0] fc_o;
  logic [AW-1:0] addr_o;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  bus_cycle_master #(.AW(AW), .DW(DW), .FW(FW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .rw_i(rw),
    .addr_i(addr), .fc_i(fc), .be_i(be), .wdata_i(wdata),
    .rdata_o(rdata_o), .done_o(done_o), .bclk_o(bclk_o), .fc_o(fc_o),
    .addr_o(addr_o), .as_n_o(as_n_o), .uds_n_o(uds_n_o), .lds_n_o(lds_n_o),
    .rw_o(rw_o), .data_o(data_o), .data_oe_o(data_oe_o),
    .data_i(din), .dtack_n_i(dtack_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_chk(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, {as_n_o, uds_n_o, lds_n_o, done_o, data_oe_o}, 5'b11100);
      chk(req, addr_o, '0);
    end
  endtask

  // clock k counts from the edge entering S0
  task automatic run(input vec_t v, input bit busy_start);
    int l;
    bit as_w, ds_w;
    l = (v.j <= 3) ? 0 : 2 * ((int'(v.j) - 2) / 2);
    while (bclk_o !== 1'b0) @(negedge clk);
    start = 1'b1; rw = v.rd; be = v.be; fc = v.fc; addr = v.addr;
    wdata = v.wdata; din = v.rdata; dtack_n = 1'b1;
    for (int k = 0; k <= 10 + l; k++) begin
      @(negedge clk);
      if (k == 0) start = 1'b0;
      as_w = (k >= 2) && (k <= 6 + l);
      ds_w = v.rd ? as_w : ((k >= 4) && (k <= 6 + l));
      chk("R1 bclk", bclk_o, (k % 2) == 0);
      chk("R3 as_n", as_n_o, !as_w);
      chk(v.rd ? "R3 uds_n" : "R4 uds_n", uds_n_o, !(ds_w && v.be[1]));
      chk(v.rd ? "R3 lds_n" : "R4 lds_n", lds_n_o, !(ds_w && v.be[0]));
      chk("R4 rw", rw_o, v.rd || !as_w);
      chk("R7 data_oe", data_oe_o, !v.rd && k >= 3 && k <= 8 + l);
      chk("R5 R6 done", done_o, k == 7 + l);
      chk("R2 fc", fc_o, (k <= 7 + l) ? v.fc : '0);
      chk("R2 addr", addr_o, (k >= 1 && k <= 7 + l) ? v.addr : '0);
      if (!v.rd && k == 3) chk("R7 data", data_o, v.wdata);
      if (v.rd && k == 7 + l) chk("R8 rdata", rdata_o, v.rdata);
      if (k == int'(v.j) - 1) dtack_n = 1'b0;
      if (k == 7 + l) dtack_n = 1'b1;
      if (busy_start && k == 3) begin start = 1'b1; addr = ~v.addr; end
      if (busy_start && k == 8 + l) start = 1'b0;
    end
    din = '0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    // R10 reset state
    chk("R10 reset", {as_n_o, uds_n_o, lds_n_o, rw_o, data_oe_o, done_o, bclk_o}, 7'b1111000);
    chk("R10 reset addr", {addr_o, fc_o}, '0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run(VECS[i], 1'b0);
      repeat (4) @(negedge clk);
    end

    // R9 no byte selects: start has no effect
    start = 1'b1; be = 2'b00; rw = 1'b1; addr = 24'h00_0055;
    idle_chk("R9 no be", 3);
    start = 1'b0;
    idle_chk("R9 no be", 5);

    // R9 start while busy is ignored
    run('{1'b1, 2'b11, 3'd4, 24'h03_0303, 16'h0, 16'h2468, 4'd1}, 1'b1);
    idle_chk("R9 busy", 6);

    // R1 start in high bus-clock half waits one clock
    while (bclk_o !== 1'b1) @(negedge clk);
    start = 1'b1; be = 2'b11; rw = 1'b1; addr = 24'h00_0aaa; dtack_n = 1'b0;
    @(negedge clk); start = 1'b0;
    chk("R1 align as_n", as_n_o, 1'b1);
    chk("R1 align fc", fc_o, '0);
    @(negedge clk);
    chk("R1 align S0 bclk", bclk_o, 1'b1);
    chk("R1 align S0 addr", addr_o, '0);
    repeat (2) @(negedge clk);
    chk("R1 align S2 as_n", as_n_o, 1'b0);
    repeat (10) @(negedge clk);
    dtack_n = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule